// File: doc/BRIEF.md
# DRAM mode register init sequencer

This block walks a freshly powered DRAM through its mode register programming once the PHY has finished power-up. A one-cycle `start` pulse latches the memory type (DDR3, LPDDR2 or LPDDR3) and the mode register values. The block then issues a fixed, type-dependent list of commands on a 32-bit command word. Each command carries a start flag and an all-ranks mask. It stays on the port until the downstream command engine clears the start flag, which it signals with `cmd_clr`.

Between commands the sequencer inserts the waits the memory needs. These are a one-cycle gap by default, and 1 µs or 10 µs gaps after the commands that need settling time. The length of a microsecond in clock cycles is a parameter. When the last command has been accepted, `done` pulses once and `busy` falls. Command codes are DESEL = 4'h1, PREA = 4'h2, MRS = 4'h3 and ZQCL = 4'h4, carried in bits [3:0]. Bits [30:22] are always zero.

Top module: `mrinit_seq`

## Requirements
- R1: Every command word has bit 31 (start) set and the value 2'b11 in bits [21:20], addressing both ranks.
- R2: A command word is held unchanged with bit 31 high until `cmd_clr` is sampled high. Bit 31 is then low for at least one cycle before the next command appears. The first command appears in the cycle after `start` is sampled.
- R3: For memory type 2'd0 (DDR3), the commands are issued in this order: DESEL, PREA, MRS to MR2, MRS to MR3, MRS to MR1, MRS to MR0, ZQCL. An MRS carries the register number in bits [19:17] and the 13-bit value in bits [16:4].
- R4: For DDR3, the MR0 write carries the configured MR0 value with bit 8 (DLL reset) forced to 1.
- R5: For DDR3, bit 31 stays low for CYC_PER_US cycles after DESEL is accepted. Every other gap between DDR3 commands is one cycle.
- R6: For the LPDDR types, the first command is an MRS to register 63 with opcode 0. It is followed by a low gap of 10*CYC_PER_US cycles. An LPDDR MRS carries the register number in bits [11:4] and the opcode in bits [19:12].
- R7: For the LPDDR types, register 10 is then written twice with opcode 8'hFF, each write followed by a CYC_PER_US-cycle gap. Registers 1, 2 and 3 follow, using the low 8 bits of the configured values, with one-cycle gaps.
- R8: Type 2'd2 (LPDDR3) adds a final MRS to register 11 with the `mr11` value. Types 2'd1 and 2'd3 end after register 3 and are handled identically.
- R9: `done` is high for exactly one cycle: the cycle after the edge that samples `cmd_clr` for the last command.
- R10: `busy` is high from the cycle after `start` is sampled until `done` rises. While `busy` is high, `start` is ignored. While idle, no command is presented.
- R11: The type and mode register inputs are captured when `start` is sampled. Later changes have no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run the sequence |
| mem_type | input | 2 | 0 DDR3, 1 LPDDR2, 2 LPDDR3, 3 treated as LPDDR2 |
| mr0 | input | 13 | Mode register 0 value |
| mr1 | input | 13 | Mode register 1 value (LPDDR uses bits [7:0]) |
| mr2 | input | 13 | Mode register 2 value (LPDDR uses bits [7:0]) |
| mr3 | input | 13 | Mode register 3 value (LPDDR uses bits [7:0]) |
| mr11 | input | 8 | LPDDR3 register 11 opcode |
| cmd_clr | input | 1 | Downstream has cleared the start bit of the pending command |
| cmd_word | output | 32 | Command word; bit 31 is the start flag |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every type code, including the reserved one, is run with random 13-bit mode register values. This separates the DDR3 bank/address field placement from the LPDDR register/opcode placement, and shows whether the MR11 write depends only on type 2. The acceptance delay is randomized, and the width of every low gap is measured. This distinguishes the 1 µs and 10 µs waits from the plain one-cycle spacing and exposes any command issued early. The inputs are scrambled right after `start`, and a second `start` is pulsed mid-sequence. These two patterns tell a design that captures its configuration apart from one that reads it live or restarts.

// File: rtl/mrinit_pkg.sv
package mrinit_pkg;

    localparam int WORD_W        = 32;
    localparam int DDR_ADDR_W    = 13;
    localparam int LP_FIELD_W    = 8;
    localparam int PAYLOAD_W     = 20;
    localparam int DLL_RESET_BIT = 8;
    localparam logic [1:0] RANK_ALL = 2'b11;

    typedef enum logic [1:0] {
        MT_DDR3   = 2'd0,
        MT_LPDDR2 = 2'd1,
        MT_LPDDR3 = 2'd2,
        MT_RSVD   = 2'd3
    } mem_type_e;

    typedef enum logic [3:0] {
        OP_DESEL = 4'h1,
        OP_PREA  = 4'h2,
        OP_MRS   = 4'h3,
        OP_ZQCL  = 4'h4
    } cmd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } seq_st_e;

    typedef struct packed {
        mem_type_e             mtype;
        logic [DDR_ADDR_W-1:0] mr0;
        logic [DDR_ADDR_W-1:0] mr1;
        logic [DDR_ADDR_W-1:0] mr2;
        logic [DDR_ADDR_W-1:0] mr3;
        logic [LP_FIELD_W-1:0] mr11;
    } cfg_t;

    typedef struct packed {
        logic [PAYLOAD_W-1:0] payload;
        logic [3:0]           gap_us;
        logic                 last;
    } step_t;

endpackage

// File: rtl/mrinit_step_rom.sv
module mrinit_step_rom
    import mrinit_pkg::*;
#(
    parameter int STEP_W = 4
)(
    input  cfg_t              cfg,
    input  logic [STEP_W-1:0] idx,
    output step_t             step
);

    function automatic step_t mk(input logic [PAYLOAD_W-1:0] p,
                                 input logic [3:0] g, input logic l);
        step_t s;
        s.payload = p;
        s.gap_us  = g;
        s.last    = l;
        return s;
    endfunction

    function automatic logic [PAYLOAD_W-1:0] ddr_mrs(input logic [2:0] ba,
                                                     input logic [DDR_ADDR_W-1:0] a);
        return {ba, a, 4'(OP_MRS)};
    endfunction

    function automatic logic [PAYLOAD_W-1:0] lp_mrs(input logic [LP_FIELD_W-1:0] ma,
                                                    input logic [LP_FIELD_W-1:0] op);
        return {op, ma, 4'(OP_MRS)};
    endfunction

    logic [DDR_ADDR_W-1:0] mr0_dll;
    logic                  is_lp3;

    always_comb begin
        mr0_dll = cfg.mr0 | (DDR_ADDR_W'(1) << DLL_RESET_BIT);
        is_lp3  = (cfg.mtype == MT_LPDDR3);
        step    = mk('0, 4'd0, 1'b1);
        if (cfg.mtype == MT_DDR3) begin
            case (idx)
                STEP_W'(0): step = mk({16'b0, 4'(OP_DESEL)}, 4'd1, 1'b0);
                STEP_W'(1): step = mk({16'b0, 4'(OP_PREA)},  4'd0, 1'b0);
                STEP_W'(2): step = mk(ddr_mrs(3'd2, cfg.mr2), 4'd0, 1'b0);
                STEP_W'(3): step = mk(ddr_mrs(3'd3, cfg.mr3), 4'd0, 1'b0);
                STEP_W'(4): step = mk(ddr_mrs(3'd1, cfg.mr1), 4'd0, 1'b0);
                STEP_W'(5): step = mk(ddr_mrs(3'd0, mr0_dll), 4'd0, 1'b0);
                STEP_W'(6): step = mk({16'b0, 4'(OP_ZQCL)},  4'd0, 1'b1);
                default:    step = mk('0, 4'd0, 1'b1);
            endcase
        end else begin
            case (idx)
                STEP_W'(0): step = mk(lp_mrs(8'd63, 8'h00), 4'd10, 1'b0);
                STEP_W'(1): step = mk(lp_mrs(8'd10, 8'hFF), 4'd1, 1'b0);
                STEP_W'(2): step = mk(lp_mrs(8'd10, 8'hFF), 4'd1, 1'b0);
                STEP_W'(3): step = mk(lp_mrs(8'd1, cfg.mr1[LP_FIELD_W-1:0]), 4'd0, 1'b0);
                STEP_W'(4): step = mk(lp_mrs(8'd2, cfg.mr2[LP_FIELD_W-1:0]), 4'd0, 1'b0);
                STEP_W'(5): step = mk(lp_mrs(8'd3, cfg.mr3[LP_FIELD_W-1:0]), 4'd0, !is_lp3);
                STEP_W'(6): step = mk(lp_mrs(8'd11, cfg.mr11), 4'd0, 1'b1);
                default:    step = mk('0, 4'd0, 1'b1);
            endcase
        end
    end

endmodule

// File: rtl/mrinit_gap_timer.sv
module mrinit_gap_timer #(
    parameter int CNT_W = 11
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == CNT_W'(1));

    AST_GAP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> load_val != '0); // R5
    AST_GAP_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - 1'b1); // R7

endmodule

// File: rtl/mrinit_seq.sv
module mrinit_seq
    import mrinit_pkg::*;
#(
    parameter int CYC_PER_US = 125,
    parameter int STEP_W     = 4
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [1:0]            mem_type,
    input  logic [DDR_ADDR_W-1:0] mr0,
    input  logic [DDR_ADDR_W-1:0] mr1,
    input  logic [DDR_ADDR_W-1:0] mr2,
    input  logic [DDR_ADDR_W-1:0] mr3,
    input  logic [LP_FIELD_W-1:0] mr11,
    input  logic                  cmd_clr,
    output logic [WORD_W-1:0]     cmd_word,
    output logic                  busy,
    output logic                  done
);

    localparam int LONG_US = 10;
    localparam int GAP_W   = $clog2(LONG_US * CYC_PER_US + 1);
    localparam int PAD_W   = WORD_W - 1 - 2 - PAYLOAD_W;

    typedef struct packed {
        seq_st_e           st;
        logic [STEP_W-1:0] idx;
        cfg_t              cfg;
        logic              done;
    } regs_t;

    regs_t             q, d;
    step_t             step;
    logic              tmr_load;
    logic [GAP_W-1:0]  tmr_val;
    logic              tmr_expire;

    mrinit_step_rom #(.STEP_W(STEP_W)) u_rom (
        .cfg  (q.cfg),
        .idx  (q.idx),
        .step (step)
    );

    mrinit_gap_timer #(.CNT_W(GAP_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = GAP_W'(1);
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st        = ST_ISSUE;
                    d.idx       = '0;
                    d.cfg.mtype = mem_type_e'(mem_type);
                    d.cfg.mr0   = mr0;
                    d.cfg.mr1   = mr1;
                    d.cfg.mr2   = mr2;
                    d.cfg.mr3   = mr3;
                    d.cfg.mr11  = mr11;
                end
            end
            ST_ISSUE: begin
                if (cmd_clr) begin
                    if (step.last) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st     = ST_WAIT;
                        d.idx    = q.idx + 1'b1;
                        tmr_load = 1'b1;
                        if (step.gap_us != 4'd0)
                            tmr_val = GAP_W'(32'(step.gap_us) * CYC_PER_US);
                    end
                end
            end
            ST_WAIT: begin
                if (tmr_expire)
                    d.st = ST_ISSUE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.idx  <= '0;
            q.cfg  <= '0;
            q.done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cmd_word = (q.st == ST_ISSUE) ? {1'b1, {PAD_W{1'b0}}, RANK_ALL, step.payload}
                                         : '0;
    assign busy = (q.st != ST_IDLE);
    assign done = q.done;

    AST_RANK_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_word[WORD_W-1] |-> cmd_word[21:20] == 2'b11); // R1
    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_word[WORD_W-1] && !cmd_clr) |=> $stable(cmd_word)); // R2
    AST_DROP_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_word[WORD_W-1] && cmd_clr) |=> !cmd_word[WORD_W-1]); // R2
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cmd_word[WORD_W-1] && cmd_clr)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_word[WORD_W-1]); // R10
    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R10

endmodule

// File: tb/sim_mrinit_seq.sv
module sim_mrinit_seq;

    localparam int CPU = 125;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mem_type = 2'd0;
    logic [12:0] mr0 = '0, mr1 = '0, mr2 = '0, mr3 = '0;
    logic [7:0]  mr11 = '0;
    logic        cmd_clr = 1'b0;
    logic [31:0] cmd_word;
    logic        busy, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mrinit_seq #(.CYC_PER_US(CPU)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_type(mem_type),
        .mr0(mr0), .mr1(mr1), .mr2(mr2), .mr3(mr3), .mr11(mr11),
        .cmd_clr(cmd_clr), .cmd_word(cmd_word), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int exp_count(input int t);
        return (t == 2) ? 7 : (t == 0) ? 7 : 6;
    endfunction

    function automatic logic [31:0] exp_word(input int t, input int i,
            input logic [12:0] a0, input logic [12:0] a1, input logic [12:0] a2,
            input logic [12:0] a3, input logic [7:0] a11);
        logic [31:0] b;
        b = 32'h8000_0000 + 32'h0030_0000;
        if (t == 0) begin
            case (i)
                0: return b + 1;
                1: return b + 2;
                2: return b + 3 + (2 * 32'h2_0000) + 32'(a2) * 16;
                3: return b + 3 + (3 * 32'h2_0000) + 32'(a3) * 16;
                4: return b + 3 + (1 * 32'h2_0000) + 32'(a1) * 16;
                5: return b + 3 + 32'(a0 | 13'h100) * 16;
                default: return b + 4;
            endcase
        end else begin
            case (i)
                0: return b + 3 + 63 * 16;
                1, 2: return b + 3 + 10 * 16 + 255 * 4096;
                3: return b + 3 + 1 * 16 + 32'(a1[7:0]) * 4096;
                4: return b + 3 + 2 * 16 + 32'(a2[7:0]) * 4096;
                5: return b + 3 + 3 * 16 + 32'(a3[7:0]) * 4096;
                default: return b + 3 + 11 * 16 + 32'(a11) * 4096;
            endcase
        end
    endfunction

    function automatic int exp_gap(input int t, input int i);
        if (i == 0) return 0;
        if (t == 0) return (i == 1) ? CPU : 1;
        if (i == 1) return 10 * CPU;
        if (i == 2 || i == 3) return CPU;
        return 1;
    endfunction

    task automatic run_seq(input int t, input bit poke);
        logic [12:0] a0, a1, a2, a3;
        logic [7:0]  a11;
        int n;
        a0 = 13'($urandom); a1 = 13'($urandom); a2 = 13'($urandom);
        a3 = 13'($urandom); a11 = 8'($urandom);
        n = exp_count(t);
        @(negedge clk);
        mem_type = 2'(t); mr0 = a0; mr1 = a1; mr2 = a2; mr3 = a3; mr11 = a11;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R11: scramble configuration after capture
        mem_type = 2'($urandom); mr0 = 13'($urandom); mr1 = 13'($urandom);
        mr2 = 13'($urandom); mr3 = 13'($urandom); mr11 = 8'($urandom);
        for (int i = 0; i < n; i++) begin
            int low;
            int dly;
            logic [31:0] w;
            low = 0;
            while (!cmd_word[31] && low < 20000) begin
                low++;
                @(negedge clk);
            end
            if (t == 0) chk(low == exp_gap(t, i), "R5", "gap", 32'(low), 32'(exp_gap(t, i)));
            else if (i < 3) chk(low == exp_gap(t, i), "R6", "gap", 32'(low), 32'(exp_gap(t, i)));
            else chk(low == exp_gap(t, i), "R7", "gap", 32'(low), 32'(exp_gap(t, i)));
            chk(busy == 1'b1, "R10", "busy during sequence", 32'(busy), 32'd1);
            w = exp_word(t, i, a0, a1, a2, a3, a11);
            chk(cmd_word[21:20] == 2'b11 && cmd_word[31], "R1", "rank/start", cmd_word, w);
            if (t == 0) begin
                if (i == 5) chk(cmd_word == w, "R4", "MR0 word", cmd_word, w);
                else chk(cmd_word == w, "R3", "DDR3 word", cmd_word, w);
            end else begin
                if (i == 6) chk(cmd_word == w, "R8", "MR11 word", cmd_word, w);
                else if (i == 0) chk(cmd_word == w, "R6", "reset word", cmd_word, w);
                else chk(cmd_word == w, "R7", "LPDDR word", cmd_word, w);
            end
            dly = $urandom_range(0, 4);
            if (poke && i == 2) begin
                dly = dly + 1;
                start = 1'b1;
            end
            for (int k = 0; k < dly; k++) begin
                @(negedge clk);
                start = 1'b0;
                chk(cmd_word == w, "R2", "word held", cmd_word, w);
            end
            cmd_clr = 1'b1;
            @(negedge clk);
            cmd_clr = 1'b0;
            chk(!cmd_word[31], "R2", "start cleared", cmd_word, 32'h0);
            if (i == n - 1) begin
                chk(done == 1'b1, "R9", "done pulse", 32'(done), 32'd1);
                chk(busy == 1'b0, "R10", "busy falls", 32'(busy), 32'd0);
                @(negedge clk);
                chk(done == 1'b0, "R9", "done one cycle", 32'(done), 32'd0);
            end else begin
                chk(done == 1'b0, "R9", "no early done", 32'(done), 32'd0);
            end
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(cmd_word == 32'h0, "R8", "no further command", cmd_word, 32'h0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(cmd_word == 32'h0, "R10", "reset word", cmd_word, 32'h0);
        chk(busy == 1'b0, "R10", "reset busy", 32'(busy), 32'd0);
        chk(done == 1'b0, "R9", "reset done", 32'(done), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // directed corners
        run_seq(0, 1'b0);
        run_seq(1, 1'b0);
        run_seq(2, 1'b0);
        run_seq(3, 1'b0);   // R8: reserved code behaves as LPDDR2
        run_seq(0, 1'b1);   // R10: start while busy ignored
        run_seq(2, 1'b1);
        // random mix
        for (int s = 0; s < 24; s++)
            run_seq(int'($urandom_range(0, 3)), 1'b0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 190000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule